// File: doc/BRIEF.md
# Shared Channel Ownership Arbiter

This block decides who drives one shared auxiliary-channel engine. Two masters compete for it: a software host and an embedded microcontroller. Each master has a level-held request input and a single-cycle release pulse. A 2-bit owner status output reports the current owner: 0 when idle, 1 when the host owns the channel, 2 when the microcontroller owns it. The encoding 3 never appears.

The microcontroller is granted on the cycle after it requests, provided the channel is idle. The host is granted only after a bring-up sequence on the engine. The enable line is raised first. When `HAS_RESET` is set, engine reset is then pulsed. The arbiter waits for the reset-done flag to rise, drops reset, and waits for the flag to fall again before the owner status reads 1. A small internal reset-response counter raises reset-done `RST_LAT` cycles after reset is asserted. It clears the flag one cycle after reset falls. Either owner gives the channel back with its release pulse, and a release from the side that does not own the channel has no effect.

States:
- `ST_IDLE`: no owner.
- `ST_ENABLE`: engine enable raised.
- `ST_RESET`: engine reset held until reset-done reads 1.
- `ST_UNRESET`: reset low until reset-done reads 0.
- `ST_HOST`: host owns the channel.
- `ST_MCU`: microcontroller owns the channel.

Transitions:
- `ST_IDLE` to `ST_MCU` on a microcontroller request. This wins even if the host requests in the same cycle.
- `ST_IDLE` to `ST_ENABLE` on a host request alone.
- `ST_ENABLE` to `ST_RESET`, or straight to `ST_HOST` when there is no reset support.
- `ST_RESET` to `ST_UNRESET` when reset-done is 1.
- `ST_UNRESET` to `ST_HOST` when reset-done is 0.
- `ST_HOST` to `ST_IDLE` on a host release.
- `ST_MCU` to `ST_IDLE` on a microcontroller release.

Top module: `chan_own_arb`

## Requirements
- R1: After reset, the owner status is 0, and engine enable and engine reset are both 0.
- R2: The owner status is 0 when idle, 1 when the host owns the channel, and 2 when the microcontroller owns it. It never reads 3.
- R3: When both masters request while the channel is idle, the microcontroller is granted: the status reads 2 after the next clock edge.
- R4: While the microcontroller owns the channel, a host request is not granted and the status stays 2.
- R5: Engine enable is 1 in every non-idle state and 0 when idle. It rises one cycle before engine reset rises, and engine reset is never 1 while enable is 0.
- R6: With the default `RST_LAT`=4, a host request from idle leads to a status of 1 after exactly `RST_LAT`+5 clock edges. During that interval engine reset is high for exactly `RST_LAT`+1 cycles, and the status reads 0 until the grant.
- R7: Engine reset falls only after reset-done has risen. The host is granted only once reset-done has returned to 0.
- R8: A host release pulse while the host owns the channel makes the status 0 after the next edge, and engine enable drops with it.
- R9: A microcontroller release pulse while the microcontroller owns the channel makes the status 0 after the next edge.
- R10: A release pulse from the master that does not own the channel, or a release pulse while idle, leaves the status unchanged.
- R11: A microcontroller request raised during the host's bring-up sequence does not abort it. The microcontroller is granted on the edge after the host releases the channel, if its request is still held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | Host access request, level held |
| host_done | input | 1 | Host release pulse |
| mcu_req | input | 1 | Microcontroller access request, level held |
| mcu_done | input | 1 | Microcontroller release pulse |
| owner_status | output | 2 | 0 idle, 1 host owns, 2 microcontroller owns |
| eng_enable | output | 1 | Engine enable |
| eng_reset | output | 1 | Engine reset |

## Verification
A vector table drives single-cycle combinations of requests and releases. These separate microcontroller priority on a simultaneous request, host requests refused while the microcontroller owns the channel, and release pulses from the wrong side or while idle. Directed host acquisitions count the edges to the grant and the cycles reset stays high. These counts distinguish a correct enable-then-reset handshake from one that skips the reset-done wait or grants early. A microcontroller request raised during the host's bring-up checks that the sequence is not aborted and that the hand-over happens right after the host releases.

// File: rtl/chan_own_pkg.sv
package chan_own_pkg;
    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_HOST = 2'd1,
        OWN_MCU  = 2'd2
    } owner_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ENABLE,
        ST_RESET,
        ST_UNRESET,
        ST_HOST,
        ST_MCU
    } own_state_e;
endpackage

// File: rtl/chan_rst_resp.sv
module chan_rst_resp #(
    parameter int RST_LAT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic eng_reset,
    output logic rst_done
);
    localparam int CNT_W = $clog2(RST_LAT + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RST_LAT);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!eng_reset) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign rst_done = (cnt_q == CNT_MAX);

    // R7: once raised, done stays up while reset is held
    assert_done_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_done && eng_reset) |=> rst_done);
endmodule

// File: rtl/chan_own_fsm.sv
module chan_own_fsm
    import chan_own_pkg::*;
#(
    parameter bit HAS_RESET = 1'b1
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   host_req,
    input  logic   host_done,
    input  logic   mcu_req,
    input  logic   mcu_done,
    input  logic   rst_done,
    output owner_e owner,
    output logic   eng_enable,
    output logic   eng_reset
);
    own_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (mcu_req)       state_d = ST_MCU;
                else if (host_req) state_d = ST_ENABLE;
            end
            ST_ENABLE:  state_d = HAS_RESET ? ST_RESET : ST_HOST;
            ST_RESET:   if (rst_done)  state_d = ST_UNRESET;
            ST_UNRESET: if (!rst_done) state_d = ST_HOST;
            ST_HOST:    if (host_done) state_d = ST_IDLE;
            ST_MCU:     if (mcu_done)  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        owner      = OWN_NONE;
        eng_enable = 1'b1;
        eng_reset  = 1'b0;
        unique case (state_q)
            ST_IDLE:    eng_enable = 1'b0;
            ST_ENABLE:  ;
            ST_RESET:   eng_reset = 1'b1;
            ST_UNRESET: ;
            ST_HOST:    owner = OWN_HOST;
            ST_MCU:     owner = OWN_MCU;
            default:    eng_enable = 1'b0;
        endcase
    end

    // R3: microcontroller wins from idle
    assert_mcu_priority_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (owner == OWN_NONE && !eng_enable && mcu_req) |=> owner == OWN_MCU);
    // R4: host cannot take a microcontroller-owned channel
    assert_no_host_steal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (owner == OWN_MCU && !mcu_done) |=> owner == OWN_MCU);
    // R10: host keeps the channel across foreign releases
    assert_nonowner_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (owner == OWN_HOST && !host_done) |=> owner == OWN_HOST);
    // R8: host release frees the channel
    assert_host_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (owner == OWN_HOST && host_done) |=> (owner == OWN_NONE && !eng_enable));
endmodule

// File: rtl/chan_own_arb.sv
module chan_own_arb
    import chan_own_pkg::*;
#(
    parameter bit HAS_RESET = 1'b1,
    parameter int RST_LAT   = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_req,
    input  logic       host_done,
    input  logic       mcu_req,
    input  logic       mcu_done,
    output logic [1:0] owner_status,
    output logic       eng_enable,
    output logic       eng_reset
);
    owner_e owner;
    logic   rst_done;

    generate
        if (HAS_RESET) begin : g_rst
            chan_rst_resp #(.RST_LAT(RST_LAT)) u_rst (
                .clk      (clk),
                .rst_n    (rst_n),
                .eng_reset(eng_reset),
                .rst_done (rst_done)
            );
        end else begin : g_norst
            assign rst_done = 1'b0;
        end
    endgenerate

    chan_own_fsm #(.HAS_RESET(HAS_RESET)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_req  (host_req),
        .host_done (host_done),
        .mcu_req   (mcu_req),
        .mcu_done  (mcu_done),
        .rst_done  (rst_done),
        .owner     (owner),
        .eng_enable(eng_enable),
        .eng_reset (eng_reset)
    );

    assign owner_status = owner;

    // R2: encoding 3 is never reported
    always @(posedge clk) begin
        if (rst_n) assert_status_legal_R2: assert (owner_status != 2'd3);
    end
    // R5: reset only under enable
    assert_reset_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        eng_reset |-> eng_enable);
    // R7: reset falls only after done was seen
    assert_reset_fall_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_reset && !rst_done) |=> eng_reset);
    // R7: host grant only with done back low
    assert_grant_after_done_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_status == 2'd1 && $past(owner_status) == 2'd0) |-> !rst_done);
endmodule

// File: tb/chan_own_arb_tb.sv
module chan_own_arb_tb;
    localparam int RST_LAT = 4;
    localparam int NV = 9;
    // [5] mcu_req [4] host_req [3] mcu_done [2] host_done [1:0] expected status
    localparam logic [5:0] VEC [NV] = '{
        6'b0000_00,  // idle stays 0
        6'b1000_10,  // mcu request -> 2
        6'b0100_10,  // host request refused (R4)
        6'b0101_10,  // host release while mcu owns ignored (R10)
        6'b0010_00,  // mcu release (R9)
        6'b1100_10,  // both request: mcu wins (R3)
        6'b0010_00,  // mcu release
        6'b0010_00,  // mcu release while idle ignored (R10)
        6'b0001_00   // host release while idle ignored (R10)
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_req = 1'b0, host_done = 1'b0, mcu_req = 1'b0, mcu_done = 1'b0;
    logic [1:0] owner_status;
    logic eng_enable, eng_reset;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    chan_own_arb #(.HAS_RESET(1'b1), .RST_LAT(RST_LAT)) u_dut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_done(host_done),
        .mcu_req(mcu_req), .mcu_done(mcu_done), .owner_status(owner_status),
        .eng_enable(eng_enable), .eng_reset(eng_reset)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic step(input logic mr, input logic hr, input logic md, input logic hd);
        @(negedge clk);
        mcu_req = mr; host_req = hr; mcu_done = md; host_done = hd;
        @(posedge clk);
        #1;
        mcu_done = 1'b0; host_done = 1'b0;
    endtask

    // host acquisition; returns edges to grant and reset-high cycles
    task automatic host_acquire(output int edges, output int rst_hi, output int bad);
        edges = 0; rst_hi = 0; bad = 0;
        @(negedge clk);
        host_req = 1'b1;
        for (int i = 0; i < 40; i++) begin
            @(posedge clk);
            #1;
            edges++;
            if (eng_reset) rst_hi++;
            if (eng_reset && !eng_enable) bad++;
            if (edges == 1 && (eng_reset || !eng_enable)) bad++;
            if (owner_status == 2'd1) break;
            if (owner_status != 2'd0) bad++;
        end
    endtask

    initial begin
        #(10 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int e, r, b;
        #12;
        check("R1 status", owner_status, 0);
        check("R1 enable", eng_enable, 0);
        check("R1 reset", eng_reset, 0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            step(VEC[k][5], VEC[k][4], VEC[k][3], VEC[k][2]);
            check($sformatf("R2/R3/R4/R9/R10 vector %0d", k), owner_status, VEC[k][1:0]);
            check($sformatf("R5 enable vector %0d", k), eng_enable, (VEC[k][1:0] != 2'd0));
        end

        // R6 R5 R7: host bring-up sequence
        host_acquire(e, r, b);
        check("R6 edges to host grant", e, RST_LAT + 5);
        check("R6 reset high cycles", r, RST_LAT + 1);
        check("R5 enable ordering / R6 status 0 during setup", b, 0);
        check("R2 host status", owner_status, 1);
        step(1'b1, 1'b0, 1'b0, 1'b0);
        check("R4 mcu waits while host owns", owner_status, 1);
        step(1'b1, 1'b0, 1'b1, 1'b0);
        check("R10 mcu release while host owns", owner_status, 1);
        step(1'b1, 1'b0, 1'b0, 1'b1);
        check("R8 host release", owner_status, 0);
        check("R8 enable drops", eng_enable, 0);
        step(1'b1, 1'b0, 1'b0, 1'b0);
        check("R11 mcu granted after host release", owner_status, 2);
        step(1'b0, 1'b0, 1'b1, 1'b0);
        check("R9 mcu release", owner_status, 0);

        // R11: mcu request during host bring-up does not abort it
        @(negedge clk);
        host_req = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        mcu_req = 1'b1;
        for (int i = 0; i < RST_LAT + 2; i++) @(posedge clk);
        #1;
        check("R11 host granted despite mcu request", owner_status, 1);
        step(1'b1, 1'b0, 1'b0, 1'b1);
        check("R8 release with mcu waiting", owner_status, 0);
        step(1'b1, 1'b0, 1'b0, 1'b0);
        check("R11 mcu takes over", owner_status, 2);
        step(1'b0, 1'b0, 1'b1, 1'b0);
        check("R9 final release", owner_status, 0);

        // R1: reset while owned returns to idle
        step(1'b1, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 status under reset", owner_status, 0);
        check("R1 enable under reset", eng_enable, 0);
        finish_run();
    end
endmodule